// File: doc/BRIEF.md
# Tape-Language Processor Core

This block is a small processor that executes programs for the eight-command tape-machine esoteric language. It also executes a ninth command that halts it. Byte opcodes are fetched from an external 256-byte program memory through a synchronous read port: the core drives an address, and the byte at that address comes back on the next clock. A data pointer selects one of 16 four-bit cells. These cells are the whole data store.

Loop brackets are not matched in hardware. A bracket is encoded as a two-byte conditional jump, and its second byte holds the absolute target address. That byte is captured as an address and is never executed. An opening bracket is written as jump-if-zero with a target just past the closing bracket, so a loop whose entry cell is zero runs no times. A closing bracket is written as jump-if-non-zero back to the first opcode of the body.

The print command loads an 8-bit output latch and pulses a strobe. The read command waits for an input-valid signal, then takes the low bits of the input byte. An ordinary command takes two cycles and a jump takes four.

Top module: `tape_core`

## Requirements
- R1: A synchronous reset, while asserted, clears the program counter, data pointer, all cells, the output latch and the strobe. During reset `prog_addr` is 0 and `out_data`, `out_strobe`, `halted` and `in_ack` are all 0.
- R2: Opcodes run in address order. The program counter wraps from 255 to 0.
- R3: 0x03 adds one to the current cell and 0x04 subtracts one, both modulo 16, so 15+1 gives 0 and 0-1 gives 15.
- R4: 0x01 moves the data pointer up by one and 0x02 moves it down by one. The pointer wraps at both ends (15 to 0, and 0 to 15).
- R5: 0x05 loads `out_data` with the current cell in bits 3:0 and zeros in bits 7:4, and pulses `out_strobe` high for exactly one cycle. `out_data` keeps its value until the next 0x05.
- R6: 0x06 stalls while `in_valid` is low. When `in_valid` is high, it writes `in_data[3:0]` to the current cell and raises `in_ack` for exactly one cycle. `in_ack` is never high without `in_valid`.
- R7: 0x07 is jump-if-zero and is followed by a target byte. If the current cell is 0, execution continues at the target. Otherwise it continues two bytes after the opcode. The target byte is never executed as an opcode.
- R8: 0x08 is jump-if-non-zero and is followed by a target byte. If the current cell is not 0, execution continues at the target. Otherwise it continues two bytes after the opcode.
- R9: 0x09 raises `halted` and holds `prog_addr` at the halt opcode's address until reset. No further print happens after it.
- R10: 0x00, and every byte value from 0x0A to 0xFF, changes no cell, pointer or output and only advances the program counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| prog_addr | output | 8 | Program memory read address |
| prog_data | input | 8 | Program byte, one cycle after its address |
| in_data | input | 8 | Input port byte |
| in_valid | input | 1 | Input byte is available |
| in_ack | output | 1 | Input byte taken this cycle |
| out_data | output | 8 | Output latch |
| out_strobe | output | 1 | One-cycle pulse on each print |
| halted | output | 1 | Halt command reached |

## Verification
The bench builds the core with its default parameters: an 8-bit program address, which is also the program byte width, 16 cells of 4 bits, and an 8-bit I/O width. With these values the program-counter wrap, the cell wrap at both ends and the pointer wrap can all be reached in a handful of opcodes. A directed program jumps to the top of memory and runs across address 255 back to 0. Random programs mix every opcode with junk bytes and forward jumps. Random gaps in `in_valid` stall the read command at many different points.

// File: rtl/tape_core.sv
module tape_core #(
  parameter int PC_W   = 8,
  parameter int CELL_W = 4,
  parameter int PTR_W  = 4,
  parameter int IO_W   = 8
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PC_W-1:0] prog_addr,
  input  logic [PC_W-1:0] prog_data,
  input  logic [IO_W-1:0] in_data,
  input  logic            in_valid,
  output logic            in_ack,
  output logic [IO_W-1:0] out_data,
  output logic            out_strobe,
  output logic            halted
);
  localparam int DEPTH = 1 << PTR_W;

  localparam logic [PC_W-1:0] OP_RIGHT = PC_W'(1);
  localparam logic [PC_W-1:0] OP_LEFT  = PC_W'(2);
  localparam logic [PC_W-1:0] OP_INC   = PC_W'(3);
  localparam logic [PC_W-1:0] OP_DEC   = PC_W'(4);
  localparam logic [PC_W-1:0] OP_OUT   = PC_W'(5);
  localparam logic [PC_W-1:0] OP_IN    = PC_W'(6);
  localparam logic [PC_W-1:0] OP_JZ    = PC_W'(7);
  localparam logic [PC_W-1:0] OP_JNZ   = PC_W'(8);
  localparam logic [PC_W-1:0] OP_HALT  = PC_W'(9);

  typedef enum logic [2:0] {S_FETCH, S_EXEC, S_OPADDR, S_TARGET, S_HALT} st_t;

  st_t               st;
  logic [PC_W-1:0]   pc;
  logic [PTR_W-1:0]  ptr;
  logic [CELL_W-1:0] cells [DEPTH];
  logic              jnz_q;

  wire [CELL_W-1:0] cur     = cells[ptr];
  wire              is_zero = (cur == '0);
  wire              take    = jnz_q ? !is_zero : is_zero;

  assign prog_addr = pc;
  assign halted    = (st == S_HALT);
  assign in_ack    = (st == S_EXEC) && (prog_data == OP_IN) && in_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_FETCH;
      pc         <= '0;
      ptr        <= '0;
      jnz_q      <= 1'b0;
      out_data   <= '0;
      out_strobe <= 1'b0;
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else begin
      out_strobe <= 1'b0;
      case (st)
        S_FETCH: st <= S_EXEC;
        S_EXEC: begin
          st <= S_FETCH;
          pc <= pc + 1'b1;
          case (prog_data)
            OP_RIGHT: ptr <= ptr + 1'b1;
            OP_LEFT:  ptr <= ptr - 1'b1;
            OP_INC:   cells[ptr] <= cur + 1'b1;
            OP_DEC:   cells[ptr] <= cur - 1'b1;
            OP_OUT: begin
              out_data   <= IO_W'(cur);
              out_strobe <= 1'b1;
            end
            OP_IN: begin
              if (in_valid) cells[ptr] <= in_data[CELL_W-1:0];
              else begin
                st <= S_EXEC;
                pc <= pc;
              end
            end
            OP_JZ, OP_JNZ: begin
              jnz_q <= (prog_data == OP_JNZ);
              st    <= S_OPADDR;
            end
            OP_HALT: begin
              st <= S_HALT;
              pc <= pc;
            end
            default: ;
          endcase
        end
        S_OPADDR: st <= S_TARGET;
        S_TARGET: begin
          st <= S_FETCH;
          pc <= take ? prog_data : pc + 1'b1;
        end
        default: st <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/tape_core_chk.sv
module tape_core_chk #(
  parameter int PC_W   = 8,
  parameter int CELL_W = 4,
  parameter int IO_W   = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] prog_addr,
  input logic [IO_W-1:0] in_data,
  input logic            in_valid,
  input logic            in_ack,
  input logic [IO_W-1:0] out_data,
  input logic            out_strobe,
  input logic            halted
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (prog_addr == '0) && !out_strobe && !halted && (out_data == '0));

  p_out_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
    out_strobe |-> ((out_data >> CELL_W) == '0));

  p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst)
    out_strobe |=> !out_strobe);

  p_out_holds_r5: assert property (@(posedge clk) disable iff (rst)
    !out_strobe |-> $stable(out_data));

  p_ack_needs_valid_r6: assert property (@(posedge clk) disable iff (rst)
    in_ack |-> in_valid && !$isunknown(in_data));

  p_ack_single_r6: assert property (@(posedge clk) disable iff (rst)
    in_ack |=> !in_ack);

  p_halt_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(prog_addr) && !out_strobe && !in_ack);
endmodule

bind tape_core tape_core_chk #(.PC_W(PC_W), .CELL_W(CELL_W), .IO_W(IO_W)) u_chk (
  .clk(clk), .rst(rst), .prog_addr(prog_addr), .in_data(in_data),
  .in_valid(in_valid), .in_ack(in_ack), .out_data(out_data),
  .out_strobe(out_strobe), .halted(halted)
);

// File: tb/sim_tape_core.sv
`timescale 1ns/1ps
module sim_tape_core;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1;
  logic [7:0] prog_addr, prog_data, in_data, out_data;
  logic       in_valid = 1'b0, in_ack, out_strobe, halted;

  logic [7:0] mem [256];
  always_ff @(posedge clk) prog_data <= mem[prog_addr];

  tape_core u0 (
    .clk(clk), .rst(rst), .prog_addr(prog_addr), .prog_data(prog_data),
    .in_data(in_data), .in_valid(in_valid), .in_ack(in_ack),
    .out_data(out_data), .out_strobe(out_strobe), .halted(halted)
  );

  int checks = 0, fails = 0;
  logic [7:0] inp [64];
  logic [7:0] exp_o [256];
  logic [7:0] obs [256];
  int exp_n, obs_n, exp_in, ack_n, wp;
  logic [7:0] exp_pc;

  task automatic chk(input bit ok, input string req, input int act, input int ex);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, ex);
    end
  endtask

  task automatic emit(input logic [7:0] v);
    mem[wp[7:0]] = v;
    wp++;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) mem[i] = 8'h09;
    for (int i = 0; i < 64; i++) inp[i] = 8'($urandom);
    wp = 0;
  endtask

  task automatic model();
    logic [7:0] pc;
    logic [3:0] ptr;
    logic [3:0] c [16];
    logic [7:0] op;
    pc = 0; ptr = 0; exp_n = 0; exp_in = 0;
    for (int i = 0; i < 16; i++) c[i] = 0;
    for (int s = 0; s < 5000; s++) begin
      op = mem[pc];
      if (op == 8'h09) break;
      case (op)
        8'h01: ptr = ptr + 1;
        8'h02: ptr = ptr - 1;
        8'h03: c[ptr] = c[ptr] + 1;
        8'h04: c[ptr] = c[ptr] - 1;
        8'h05: begin exp_o[exp_n] = {4'h0, c[ptr]}; exp_n++; end
        8'h06: begin c[ptr] = inp[exp_in][3:0]; exp_in++; end
        default: ;
      endcase
      if (op == 8'h07 || op == 8'h08) begin
        if ((op == 8'h07) == (c[ptr] == 0)) pc = mem[8'(pc + 1)];
        else pc = pc + 2;
      end else pc = pc + 1;
    end
    exp_pc = pc;
  endtask

  task automatic run(input string tag, input bit rnd_valid);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(prog_addr == 0 && out_data == 0 && !out_strobe && !halted && !in_ack,
        "R1", int'(prog_addr), 0);
    rst = 1'b0;
    obs_n = 0; ack_n = 0;
    for (int cyc = 0; cyc < 20000; cyc++) begin
      @(negedge clk);
      if (out_strobe && obs_n < 256) begin obs[obs_n] = out_data; obs_n++; end
      if (halted) break;
      in_valid = rnd_valid ? 1'($urandom) : 1'b1;
      in_data  = inp[ack_n < 64 ? ack_n : 63];
      #1;
      if (in_ack) ack_n++;
    end
    in_valid = 1'b0;
    model();
    chk(halted, {tag, " R9 halt reached"}, int'(halted), 1);
    chk(obs_n == exp_n, {tag, " R5 print count"}, obs_n, exp_n);
    for (int i = 0; i < exp_n && i < obs_n; i++)
      chk(obs[i] == exp_o[i], {tag, " R5 printed value"}, int'(obs[i]), int'(exp_o[i]));
    chk(ack_n == exp_in, {tag, " R6 inputs taken"}, ack_n, exp_in);
    chk(prog_addr == exp_pc, {tag, " R9 halt address"}, int'(prog_addr), int'(exp_pc));
    repeat (6) begin
      @(negedge clk);
      chk(halted && !out_strobe && prog_addr == exp_pc, "R9 frozen", int'(prog_addr), int'(exp_pc));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // R3 cell wrap both ways
    clear_prog();
    emit(8'h04); emit(8'h05); emit(8'h03); emit(8'h05); emit(8'h03); emit(8'h05);
    run("R3", 1'b0);
    // R4 pointer wrap
    clear_prog();
    emit(8'h02); emit(8'h03); emit(8'h03); emit(8'h05); emit(8'h01); emit(8'h05);
    emit(8'h02); emit(8'h05); emit(8'h01); emit(8'h01); emit(8'h02); emit(8'h05);
    run("R4", 1'b0);
    // R6 input with stalls
    clear_prog();
    inp[0] = 8'hAB; inp[1] = 8'h37;
    emit(8'h06); emit(8'h05); emit(8'h01); emit(8'h06); emit(8'h05); emit(8'h02); emit(8'h05);
    run("R6", 1'b1);
    // R8 loop multiply 3*4 with backward jump
    clear_prog();
    emit(8'h03); emit(8'h03); emit(8'h03); emit(8'h07); emit(8'd14);
    emit(8'h01); emit(8'h03); emit(8'h03); emit(8'h03); emit(8'h03); emit(8'h02);
    emit(8'h04); emit(8'h08); emit(8'd5); emit(8'h01); emit(8'h05); emit(8'h02); emit(8'h05);
    run("R8 R7", 1'b0);
    // R7 zero-entry loop skips body; operand byte 0x04 must not execute
    clear_prog();
    emit(8'h07); emit(8'd4); emit(8'h03); emit(8'h05); emit(8'h05); emit(8'h01); emit(8'h08);
    emit(8'd0); emit(8'h05);
    run("R7", 1'b0);
    // R2 program counter wrap 255 -> 0
    clear_prog();
    emit(8'h07); emit(8'd250); emit(8'h05);
    wp = 250;
    emit(8'h03); emit(8'h05); emit(8'h00); emit(8'h00); emit(8'h00); emit(8'h03);
    run("R2 R7", 1'b0);
    // R10 no-op bytes
    clear_prog();
    emit(8'h0A); emit(8'hFF); emit(8'h00); emit(8'h80); emit(8'h03); emit(8'h05);
    emit(8'h5C); emit(8'h05);
    run("R10", 1'b0);
    // R9 halt at address 0
    clear_prog();
    emit(8'h09); emit(8'h03); emit(8'h05);
    run("R9", 1'b0);
    // random programs
    for (int t = 0; t < 30; t++) begin
      int len;
      clear_prog();
      len = 40 + int'($urandom % 140);
      while (wp < len) begin
        int r;
        r = int'($urandom % 16);
        case (r)
          0, 1, 12: emit(8'h03);
          2, 13:    emit(8'h04);
          3:        emit(8'h01);
          4:        emit(8'h02);
          5, 14:    emit(8'h05);
          6:        emit(8'h06);
          7:        emit(8'h00);
          8:        emit(8'h0A + 8'($urandom % 246));
          9, 10, 11: begin
            emit(r == 11 ? 8'h08 : 8'h07);
            emit(8'(wp + 1 + int'($urandom % 20)));
          end
          default:  emit(8'h05);
        endcase
      end
      run("R2 R10 random", 1'b1);
    end
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule